// File: doc/BRIEF.md
# Serial Flash Configuration-Register Write Front End

This block is an SPI target in clock mode 0 that stands in for the command front end of a serial NOR flash. It handles only the commands that touch its nonvolatile configuration state. It holds a 32-bit boot-setup register and an 8-bit pattern register as flops. Commands can arm the write latch, write either register, read either register back, and poll a status byte. SCK, chip select and the data input are brought into the system clock domain through two-flop synchronizers. The SPI clock must therefore be several times slower than the system clock.

A write is accepted only if the write latch is armed, the engine is idle, and chip select rises exactly at the end of the last payload byte. An accepted write starts a self-timed busy period of `BUSY_CYCLES` system clocks. When that period ends, the register is updated, the write latch drops, and the error flags are set from two fault-injection inputs. A failed write keeps the old register value. While the engine is busy, only the status read is served.

The interface is a plain serial port with no valid/ready stream, so back-pressure does not arise. The host paces every bit with SCK.

Top module: `nvcfg_spi_target`

## Requirements
- R1: Opcode 06h arms the write latch (status bit 1) when chip select rises after exactly 8 bits. A register write sent while the latch is clear is ignored.
- R2: Opcode 15h followed by exactly 4 data bytes writes the 32-bit boot-setup register. The least significant byte comes first, and each byte is sent most significant bit first. The new value appears only after the busy period ends.
- R3: Opcode 14h returns the boot-setup register in the same byte and bit order as R2. Each bit is driven on MISO after a falling SCK edge, starting at the fall that follows the 8th opcode bit. A read longer than 4 bytes wraps back to the first byte.
- R4: A write frame is discarded if chip select rises after any other count of data bits, including a partial byte. The write latch keeps its value and no busy period starts.
- R5: Opcode 43h with exactly 1 data byte writes the 8-bit pattern register. Opcode 41h reads that register back, most significant bit first.
- R6: An accepted write holds the busy flag (status bit 0) at 1 for exactly `BUSY_CYCLES` system clocks, starting right after chip select rises, and then returns it to 0.
- R7: When the busy period ends, the write latch is cleared to 0.
- R8: An accepted write clears both error flags when it starts. At the end of the busy period:
  - After a 15h write, the erase-error flag (status bit 5) takes the value of `fail_erase_i` and the program-error flag (status bit 6) takes the value of `fail_prog_i`.
  - After a 43h write, only the program-error flag is updated from `fail_prog_i`.
  - A write that ends with an error leaves its register unchanged.
- R9: Opcode 05h returns the status byte {0, program error, erase error, 0, 0, 0, write latch, busy}. Status reads are served while busy. Every other opcode received while busy is ignored: arming the latch has no effect, writes are discarded, and reads return zeros.
- R10: A status read that continues past its first byte returns a freshly sampled status byte every 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host, sampled on rising SCK |
| spi_miso | output | 1 | Serial data to host, updated on falling SCK |
| fail_erase_i | input | 1 | Test input: forces an erase-phase failure on the next 32-bit write completion |
| fail_prog_i | input | 1 | Test input: forces a program-phase failure on the next write completion |

## Verification
Most faults in this block are visible only on the next status or register read, so the bench follows every stimulus with a read-back. A wrong frame-length or byte counter shows up as a write that commits when it should be discarded, or the reverse. That result is visible in the same read, as a changed register and a missing latch bit. A busy counter that is too long or too short shows up in a multi-byte status read started straight after a write: the second status byte, sampled about 96 system clocks after the first, shows whether busy has already dropped. Errors in the latch or error flags show up in the status byte read right after the busy period.

// File: rtl/nvcfg_pkg.sv
package nvcfg_pkg;

  localparam logic [7:0] OP_ARM     = 8'h06;
  localparam logic [7:0] OP_STATUS  = 8'h05;
  localparam logic [7:0] OP_BOOT_WR = 8'h15;
  localparam logic [7:0] OP_BOOT_RD = 8'h14;
  localparam logic [7:0] OP_PAT_WR  = 8'h43;
  localparam logic [7:0] OP_PAT_RD  = 8'h41;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ARM,
    CMD_STATUS,
    CMD_BOOT_WR,
    CMD_BOOT_RD,
    CMD_PAT_WR,
    CMD_PAT_RD
  } cmd_e;

  // While busy only the status poll survives decoding.
  function automatic cmd_e op_decode(input logic [7:0] op, input logic busy);
    cmd_e c;
    case (op)
      OP_ARM:     c = CMD_ARM;
      OP_STATUS:  c = CMD_STATUS;
      OP_BOOT_WR: c = CMD_BOOT_WR;
      OP_BOOT_RD: c = CMD_BOOT_RD;
      OP_PAT_WR:  c = CMD_PAT_WR;
      OP_PAT_RD:  c = CMD_PAT_RD;
      default:    c = CMD_NONE;
    endcase
    if (busy && c != CMD_STATUS) c = CMD_NONE;
    return c;
  endfunction

endpackage

// File: rtl/nvcfg_sync.sv
module nvcfg_sync #(
  parameter int          N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= din[g];
        stab_q <= meta_q;
      end
    end
    assign dout[g] = stab_q;
  end

endmodule

// File: rtl/nvcfg_shifter.sv
module nvcfg_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_s,
  input  logic       csn_s,
  input  logic       mosi_s,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       byte_stb,
  output logic [7:0] rx_byte,
  output logic       cs_rise,
  output logic       partial
);

  logic       sck_d, csn_d;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;
  logic       load_pend;
  logic       sck_rise, sck_fall;

  assign sck_rise = sck_s & ~sck_d & ~csn_s;
  assign sck_fall = ~sck_s & sck_d & ~csn_s;
  assign cs_rise  = csn_s & ~csn_d;
  assign partial  = (bit_cnt != 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      sck_d <= sck_s;
      csn_d <= csn_s;
    end
  end

  // Receive side: rising SCK samples MOSI.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= 3'd0;
      rx_sr    <= 7'd0;
      byte_stb <= 1'b0;
      rx_byte  <= 8'd0;
    end else begin
      byte_stb <= 1'b0;
      if (csn_s) begin
        bit_cnt <= 3'd0;
      end else if (sck_rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        rx_sr   <= {rx_sr[5:0], mosi_s};
        if (bit_cnt == 3'd7) begin
          byte_stb <= 1'b1;
          rx_byte  <= {rx_sr, mosi_s};
        end
      end
    end
  end

  // Transmit side: falling SCK moves the next bit onto MISO.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr     <= 8'd0;
      load_pend <= 1'b0;
      miso      <= 1'b0;
    end else if (csn_s) begin
      tx_sr     <= 8'd0;
      load_pend <= 1'b0;
      miso      <= 1'b0;
    end else begin
      if (byte_stb) load_pend <= 1'b1;
      if (sck_fall) begin
        if (load_pend) begin
          miso      <= tx_byte[7];
          tx_sr     <= {tx_byte[6:0], 1'b0};
          load_pend <= 1'b0;
        end else begin
          miso  <= tx_sr[7];
          tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/nvcfg_timer.sv
module nvcfg_timer #(
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/nvcfg_cmd.sv
module nvcfg_cmd
  import nvcfg_pkg::*;
#(
  parameter int CFG_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   byte_stb,
  input  logic [7:0]             rx_byte,
  input  logic                   cs_rise,
  input  logic                   partial,
  input  logic                   busy,
  input  logic                   done,
  input  logic                   fail_erase,
  input  logic                   fail_prog,
  output logic [7:0]             tx_byte,
  output logic                   start,
  output logic                   wel,
  output logic                   eerr,
  output logic                   perr,
  output logic [CFG_BYTES*8-1:0] cfg_q,
  output logic [7:0]             pat_q
);

  localparam int CFG_W = CFG_BYTES * 8;
  localparam int NB_W  = $clog2(CFG_BYTES + 3);
  localparam int IDX_W = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1;
  localparam logic [NB_W-1:0]  NB_MAX  = '1;
  localparam logic [NB_W-1:0]  NB_OP   = NB_W'(1);
  localparam logic [NB_W-1:0]  NB_PAT  = NB_W'(2);
  localparam logic [NB_W-1:0]  NB_BOOT = NB_W'(CFG_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(CFG_BYTES - 1);

  cmd_e             cmd_q, cmd_now;
  logic [NB_W-1:0]  nb_q;
  logic [IDX_W-1:0] rd_idx, rd_sel;
  logic [CFG_W-1:0] stg_cfg;
  logic [7:0]       stg_pat;
  logic             pend_boot;
  logic             op_byte, frame_ok;
  logic [7:0]       status;

  assign op_byte  = byte_stb && (nb_q == '0);
  assign cmd_now  = op_byte ? op_decode(rx_byte, busy) : cmd_q;
  assign rd_sel   = op_byte ? '0 : rd_idx;
  assign frame_ok = cs_rise && !partial && !busy;
  assign status   = {1'b0, perr, eerr, 3'b000, wel, busy};

  assign start = frame_ok && wel &&
                 ((cmd_q == CMD_BOOT_WR && nb_q == NB_BOOT) ||
                  (cmd_q == CMD_PAT_WR  && nb_q == NB_PAT));

  // Frame bookkeeping: byte count, latched command, read index.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nb_q    <= '0;
      cmd_q   <= CMD_NONE;
      rd_idx  <= '0;
      tx_byte <= 8'd0;
    end else if (cs_rise) begin
      nb_q   <= '0;
      cmd_q  <= CMD_NONE;
      rd_idx <= '0;
    end else if (byte_stb) begin
      if (nb_q != NB_MAX) nb_q <= nb_q + 1'b1;
      if (op_byte) cmd_q <= cmd_now;
      rd_idx <= (rd_sel == IDX_END) ? '0 : rd_sel + 1'b1;
      case (cmd_now)
        CMD_STATUS:  tx_byte <= status;
        CMD_BOOT_RD: tx_byte <= cfg_q[rd_sel*8 +: 8];
        CMD_PAT_RD:  tx_byte <= pat_q;
        default:     tx_byte <= 8'd0;
      endcase
    end
  end

  // Staging bytes for the wide register, least significant first.
  for (genvar g = 0; g < CFG_BYTES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_cfg[g*8 +: 8] <= 8'd0;
      else if (byte_stb && cmd_q == CMD_BOOT_WR && nb_q == NB_W'(g + 1))
        stg_cfg[g*8 +: 8] <= rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_pat <= 8'd0;
    else if (byte_stb && cmd_q == CMD_PAT_WR && nb_q == NB_OP) stg_pat <= rx_byte;
  end

  // Latch, error flags and committed registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel       <= 1'b0;
      eerr      <= 1'b0;
      perr      <= 1'b0;
      pend_boot <= 1'b0;
      cfg_q     <= '0;
      pat_q     <= 8'd0;
    end else begin
      if (done) wel <= 1'b0;
      else if (frame_ok && cmd_q == CMD_ARM && nb_q == NB_OP) wel <= 1'b1;

      if (start) begin
        eerr      <= 1'b0;
        perr      <= 1'b0;
        pend_boot <= (cmd_q == CMD_BOOT_WR);
      end else if (done) begin
        perr <= fail_prog;
        if (pend_boot) begin
          eerr <= fail_erase;
          if (!fail_erase && !fail_prog) cfg_q <= stg_cfg;
        end else if (!fail_prog) begin
          pat_q <= stg_pat;
        end
      end
    end
  end

endmodule

// File: rtl/nvcfg_spi_target.sv
module nvcfg_spi_target #(
  parameter int CFG_BYTES   = 4,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  input  logic fail_erase_i,
  input  logic fail_prog_i
);

  localparam int CFG_W = CFG_BYTES * 8;

  logic [2:0]       sync_out;
  logic             sck_s, csn_s, mosi_s;
  logic             byte_stb, cs_rise, partial;
  logic [7:0]       rx_byte, tx_byte;
  logic             start, busy, done;
  logic             wel, eerr, perr;
  logic [CFG_W-1:0] cfg_q;
  logic [7:0]       pat_q;

  nvcfg_sync #(.N(3), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_mosi, spi_cs_n, spi_sck}),
    .dout (sync_out)
  );

  assign sck_s  = sync_out[0];
  assign csn_s  = sync_out[1];
  assign mosi_s = sync_out[2];

  nvcfg_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck_s   (sck_s),
    .csn_s   (csn_s),
    .mosi_s  (mosi_s),
    .tx_byte (tx_byte),
    .miso    (spi_miso),
    .byte_stb(byte_stb),
    .rx_byte (rx_byte),
    .cs_rise (cs_rise),
    .partial (partial)
  );

  nvcfg_cmd #(.CFG_BYTES(CFG_BYTES)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_stb  (byte_stb),
    .rx_byte   (rx_byte),
    .cs_rise   (cs_rise),
    .partial   (partial),
    .busy      (busy),
    .done      (done),
    .fail_erase(fail_erase_i),
    .fail_prog (fail_prog_i),
    .tx_byte   (tx_byte),
    .start     (start),
    .wel       (wel),
    .eerr      (eerr),
    .perr      (perr),
    .cfg_q     (cfg_q),
    .pat_q     (pat_q)
  );

  nvcfg_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .busy (busy),
    .done (done)
  );

endmodule

// File: rtl/nvcfg_chk.sv
module nvcfg_chk #(
  parameter int CFG_W       = 32,
  parameter int BUSY_CYCLES = 1000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             wel,
  input logic             eerr,
  input logic             perr,
  input logic [CFG_W-1:0] cfg_q,
  input logic [7:0]       pat_q
);

  int run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  AST_ARM_BEFORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel)); // R1
  AST_BOOT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $fell(busy)); // R2
  AST_PAT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pat_q) |-> $fell(busy)); // R5
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_cnt < BUSY_CYCLES); // R6
  AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_cnt == BUSY_CYCLES); // R6
  AST_LATCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel); // R7
  AST_EERR_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(eerr) |-> ($rose(busy) || $fell(busy))); // R8
  AST_PERR_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(perr) |-> ($rose(busy) || $fell(busy))); // R8

endmodule

bind nvcfg_spi_target nvcfg_chk #(.CFG_W(CFG_W), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .busy (busy),
  .wel  (wel),
  .eerr (eerr),
  .perr (perr),
  .cfg_q(cfg_q),
  .pat_q(pat_q)
);

// File: tb/sim_nvcfg_spi_target.sv
`timescale 1ns/1ps
module sim_nvcfg_spi_target;

  localparam int BUSY = 180;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_mosi = 1'b0;
  logic spi_miso;
  logic fail_erase_i = 1'b0;
  logic fail_prog_i = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nvcfg_spi_target #(.CFG_BYTES(4), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .fail_erase_i(fail_erase_i), .fail_prog_i(fail_prog_i)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sends the top nbits of mo (MSB first) and returns what came back on MISO.
  task automatic xfer(input int nbits, input logic [63:0] mo, output logic [63:0] mi);
    mi = '0;
    spi_cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = mo[nbits-1-i];
      tick(HALF);
      mi = {mi[62:0], spi_miso};
      spi_sck = 1'b1;
      tick(HALF);
      spi_sck = 1'b0;
    end
    tick(HALF);
    spi_cs_n = 1'b1;
    tick(4 * HALF);
  endtask

  function automatic logic [31:0] lsb_first(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic arm();
    logic [63:0] r;
    xfer(8, 64'h06, r);
  endtask

  task automatic boot_wr(input logic [31:0] v);
    logic [63:0] r;
    xfer(40, {24'h0, 8'h15, lsb_first(v)}, r);
  endtask

  task automatic pat_wr(input logic [7:0] v);
    logic [63:0] r;
    xfer(16, {48'h0, 8'h43, v}, r);
  endtask

  task automatic status(output logic [7:0] s);
    logic [63:0] r;
    xfer(16, 64'h0500, r);
    s = r[7:0];
  endtask

  task automatic boot_rd(output logic [31:0] v);
    logic [63:0] r;
    xfer(40, {24'h0, 8'h14, 32'h0}, r);
    v = lsb_first(r[31:0]);
  endtask

  task automatic pat_rd(output logic [7:0] v);
    logic [63:0] r;
    xfer(16, 64'h4100, r);
    v = r[7:0];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  s, p;
    logic [31:0] b, cur;
    logic [63:0] r;
    logic [7:0]  pcur;

    tick(5);
    rst_n = 1'b1;
    tick(5);

    status(s);  chk("R9 reset status", s, 8'h00);
    boot_rd(b); chk("R3 reset boot", b, 32'h0);
    pat_rd(p);  chk("R5 reset pattern", p, 8'h00);

    // Write without arming is ignored.
    boot_wr(32'hCAFEF00D);
    tick(BUSY + 20);
    boot_rd(b); chk("R1 unarmed write ignored", b, 32'h0);
    status(s);  chk("R1 unarmed no busy", s, 8'h00);

    arm();
    status(s); chk("R1 arm sets latch", s, 8'h02);

    // Write, then a 3-byte status burst straight away.
    boot_wr(32'h12345678);
    tick(HALF);
    xfer(32, 64'h05000000, r);
    chk("R6 busy during write", r[23:16], 8'h03);
    chk("R10 second status byte after busy", r[15:8], 8'h00);
    chk("R7 latch cleared at end", r[7:0], 8'h00);
    boot_rd(b); chk("R2 boot value committed", b, 32'h12345678);
    cur = 32'h12345678;

    // Wrap of a long read.
    xfer(48, {16'h0, 8'h14, 32'h0, 8'h0}, r);
    chk("R3 read wraps to first byte", r[7:0], 8'h78);

    for (int k = 0; k < 8; k++) begin
      logic [31:0] v;
      v = (32'h9E3779B9 * (k + 1)) ^ (32'h00FF00FF << k);
      arm();
      boot_wr(v);
      tick(BUSY + 20);
      boot_rd(b); chk("R2 boot sweep", b, v);
      status(s);  chk("R7 status after sweep write", s, 8'h00);
      cur = v;
    end

    // Frame-length sweep for the 32-bit write.
    for (int len = 0; len <= 40; len++) begin
      logic [47:0] full;
      if (len == 32) continue;
      full = {8'h15, lsb_first(~cur), 8'hA5};
      arm();
      xfer(8 + len, {16'h0, full} >> (40 - len), r);
      tick(30);
      status(s);  chk("R4 bad boot length keeps latch idle", s, 8'h02);
      boot_rd(b); chk("R4 bad boot length no change", b, cur);
    end

    pcur = 8'h00;
    for (int k = 0; k < 16; k++) begin
      logic [7:0] v;
      v = 8'(k * 37 + 11);
      arm();
      pat_wr(v);
      tick(BUSY + 20);
      pat_rd(p); chk("R5 pattern sweep", p, v);
      pcur = v;
    end

    for (int len = 0; len <= 16; len++) begin
      if (len == 8) continue;
      arm();
      xfer(8 + len, {40'h0, 8'h43, ~pcur, 8'h5A} >> (16 - len), r);
      tick(30);
      status(s); chk("R4 bad pattern length keeps latch idle", s, 8'h02);
      pat_rd(p); chk("R4 bad pattern length no change", p, pcur);
    end

    // Arm during busy is ignored.
    arm();
    boot_wr(32'hA5A55A5A);
    arm();
    tick(BUSY);
    status(s);  chk("R9 arm ignored while busy", s, 8'h00);
    boot_rd(b); chk("R2 value after busy test", b, 32'hA5A55A5A);
    cur = 32'hA5A55A5A;

    // Read during busy returns zeros.
    arm();
    boot_wr(32'h0F1E2D3C);
    boot_rd(b); chk("R9 read while busy is zero", b, 32'h0);
    tick(BUSY);
    boot_rd(b); chk("R2 value after busy read", b, 32'h0F1E2D3C);
    cur = 32'h0F1E2D3C;

    // Error injection on the 32-bit write.
    for (int e = 1; e < 4; e++) begin
      fail_erase_i = e[0];
      fail_prog_i  = e[1];
      arm();
      boot_wr(~cur);
      tick(BUSY + 20);
      status(s);  chk("R8 boot error flags", s, {1'b0, e[1], e[0], 5'b0});
      boot_rd(b); chk("R8 failed boot write keeps value", b, cur);
    end

    // Pattern write: erase fault has no effect, program fault does.
    fail_erase_i = 1'b1;
    fail_prog_i  = 1'b0;
    arm();
    pat_wr(8'h3C);
    tick(BUSY + 20);
    status(s); chk("R8 pattern write clears flags, ignores erase fault", s, 8'h00);
    pat_rd(p); chk("R8 pattern commit with erase fault", p, 8'h3C);

    fail_erase_i = 1'b0;
    fail_prog_i  = 1'b1;
    arm();
    pat_wr(8'hC3);
    tick(BUSY + 20);
    status(s); chk("R8 pattern program error", s, 8'h40);
    pat_rd(p); chk("R8 failed pattern write keeps value", p, 8'h3C);

    fail_prog_i = 1'b0;
    arm();
    boot_wr(32'h600DF00D);
    tick(BUSY + 20);
    status(s);  chk("R8 good write clears flags", s, 8'h00);
    boot_rd(b); chk("R2 good write after errors", b, 32'h600DF00D);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule